// File: doc/BRIEF.md
# Debug Break Halt Controller

This block watches the stream of decoded instruction words that a CPU core executes. It looks for one fixed 16-bit break word. The break can take effect only when on-chip debugging is allowed. If the break is executed under that condition, the controller stops the core so that an external debugger can inspect its internal state. The core stays stopped until the debugger sends a one-cycle resume pulse. The debugger transport and the paths that reach internal resources lie outside this block.

Debugging counts as allowed when two conditions hold. Every lock bit must be clear, and both debug-enable fuses must be programmed. A fuse input reads 0 when the fuse is programmed. When debugging is not allowed, the break word acts as an ordinary one-cycle no-operation. The break word is one word long and always advances the program counter by one. No status flag is touched, so this block has no flag output.

The controller is a two-state machine:
- States:
  - `ST_RUN`: the core executes normally.
  - `ST_STOPPED`: the core is held.
- Transitions:
  - `T_ENTER` goes from `ST_RUN` to `ST_STOPPED`. It fires on a valid break word while debugging is allowed.
  - `T_RELEASE` goes from `ST_STOPPED` to `ST_RUN`. It fires on a resume pulse.
- Every other combination keeps the current state.

Top module: `brk_halt_ctrl`

## Requirements
- R1: After reset, and while reset is held, `cpu_stall` is 0 and the controller is in `ST_RUN`.
- R2: A valid word equal to 0x9598 takes transition `T_ENTER` when debugging is allowed. Debugging is allowed when `lock_bits` is all zero, `fuse_port_n` is 0 and `fuse_dbg_n` is 0. After `T_ENTER`, `cpu_stall` is 1 from the next clock edge onward.
- R3: In the cycle in which a valid break word is presented in `ST_RUN`, `pc_advance` is 1, whatever the permission.
- R4: If any bit of `lock_bits` is 1, a valid break word leaves `cpu_stall` at 0. The word acts as a no-op with `pc_advance` at 1.
- R5: If `fuse_port_n` or `fuse_dbg_n` is 1 (unprogrammed), a valid break word leaves `cpu_stall` at 0. The word acts as a no-op with `pc_advance` at 1.
- R6: In `ST_STOPPED`, `pc_advance` is 0 and every instruction word is ignored, including another break word. `cpu_stall` stays 1 until a resume pulse arrives.
- R7: A `resume_req` pulse in `ST_STOPPED` takes transition `T_RELEASE`. `cpu_stall` is 0 from the next edge, and words from that cycle onward are executed again. A `resume_req` in `ST_RUN` has no effect.
- R8: In `ST_RUN`, `pc_advance` equals `instr_valid`. A word other than 0x9598, or any word presented without `instr_valid`, never sets `cpu_stall`.
- R9: Permission is sampled only in the cycle of the break word. Changing `lock_bits` or the fuse inputs while in `ST_STOPPED` does not release the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | 16 | Instruction word being executed |
| instr_valid | input | 1 | `instr_word` is valid this cycle |
| lock_bits | input | LOCK_W | Lock-bit status; any 1 forbids debugging |
| fuse_port_n | input | 1 | Debug-port enable fuse; 0 = programmed |
| fuse_dbg_n | input | 1 | On-chip-debug enable fuse; 0 = programmed |
| resume_req | input | 1 | One-cycle resume pulse from the debugger |
| cpu_stall | output | 1 | Core held in the stopped state |
| pc_advance | output | 1 | Increment the program counter this cycle |

## Verification
Two events can arrive in the same cycle while the core is stopped: a resume pulse and a valid instruction word, which may even be another break word. The bench forces this case directly. It also lets constrained-random stimulus hit it again and again. In that cycle the bench expects `pc_advance` to be 0 and the word to be dropped. On the following edge it expects `cpu_stall` to fall. A second break must then be presented after the release before the core stops again.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int IW = 16;

    // Break opcode; fixed by the instruction encoding.
    localparam logic [IW-1:0] BRK_OPCODE = 16'h9598;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_STOPPED = 1'b1
    } brk_state_e;

endpackage

// File: rtl/brk_opcode_match.sv
module brk_opcode_match
    import brk_pkg::*;
#(
    parameter logic [IW-1:0] MATCH_WORD = BRK_OPCODE
) (
    input  logic [IW-1:0] word_i,
    input  logic          valid_i,
    output logic          hit_o
);

    always_comb begin
        hit_o = valid_i && (word_i == MATCH_WORD);
    end

endmodule

// File: rtl/brk_debug_gate.sv
module brk_debug_gate #(
    parameter int LOCK_W = 2
) (
    input  logic [LOCK_W-1:0] lock_i,
    input  logic              fuse_port_n_i,
    input  logic              fuse_dbg_n_i,
    output logic              permit_o
);

    logic any_lock;

    always_comb begin
        any_lock = |lock_i;
        // Fuses read 0 when programmed; both must be programmed.
        permit_o = !any_lock && !fuse_port_n_i && !fuse_dbg_n_i;
    end

endmodule

// File: rtl/brk_halt_fsm.sv
module brk_halt_fsm
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic brk_hit,
    input  logic permit,
    input  logic resume_req,
    output logic cpu_stall,
    output logic pc_advance
);

    brk_state_e state_q;
    brk_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (brk_hit && permit) begin
                    state_d = ST_STOPPED;   // T_ENTER
                end
            end
            ST_STOPPED: begin
                if (resume_req) begin
                    state_d = ST_RUN;       // T_RELEASE
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        cpu_stall  = 1'b0;
        pc_advance = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                pc_advance = instr_valid;
            end
            ST_STOPPED: begin
                cpu_stall = 1'b1;
            end
        endcase
    end

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && brk_hit && permit) |=> cpu_stall);

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && !resume_req) |=> cpu_stall);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && resume_req) |=> !cpu_stall);

    assert_run_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall) |-> (pc_advance == instr_valid));

    assert_stopped_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> !pc_advance);

endmodule

// File: rtl/brk_halt_ctrl.sv
module brk_halt_ctrl
    import brk_pkg::*;
#(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_word,
    input  logic              instr_valid,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic              fuse_port_n,
    input  logic              fuse_dbg_n,
    input  logic              resume_req,
    output logic              cpu_stall,
    output logic              pc_advance
);

    logic brk_hit;
    logic permit;

    brk_opcode_match #(
        .MATCH_WORD (BRK_OPCODE)
    ) u_match (
        .word_i  (instr_word),
        .valid_i (instr_valid),
        .hit_o   (brk_hit)
    );

    brk_debug_gate #(
        .LOCK_W (LOCK_W)
    ) u_gate (
        .lock_i        (lock_bits),
        .fuse_port_n_i (fuse_port_n),
        .fuse_dbg_n_i  (fuse_dbg_n),
        .permit_o      (permit)
    );

    brk_halt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .brk_hit     (brk_hit),
        .permit      (permit),
        .resume_req  (resume_req),
        .cpu_stall   (cpu_stall),
        .pc_advance  (pc_advance)
    );

    assert_locked_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && (|lock_bits)) |=> !cpu_stall);

    assert_fuse_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && (fuse_port_n || fuse_dbg_n)) |=> !cpu_stall);

    assert_break_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && instr_valid && instr_word == BRK_OPCODE) |-> pc_advance);

endmodule

// File: tb/brk_halt_ctrl_tb_top.sv
module brk_halt_ctrl_tb_top;

    localparam int LW = 2;
    localparam logic [15:0] BRKW = 16'h9598;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   instr_word = '0;
    logic          instr_valid = 1'b0;
    logic [LW-1:0] lock_bits = '0;
    logic          fuse_port_n = 1'b0;
    logic          fuse_dbg_n = 1'b0;
    logic          resume_req = 1'b0;
    logic          cpu_stall;
    logic          pc_advance;

    int    checks = 0;
    int    errors = 0;
    bit    m_stall = 1'b0;
    string m_tag = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    brk_halt_ctrl #(.LOCK_W(LW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .lock_bits   (lock_bits),
        .fuse_port_n (fuse_port_n),
        .fuse_dbg_n  (fuse_dbg_n),
        .resume_req  (resume_req),
        .cpu_stall   (cpu_stall),
        .pc_advance  (pc_advance)
    );

    function automatic bit exp_permit(logic [LW-1:0] lk, logic fp, logic fd);
        return (lk == '0) && !fp && !fd;
    endfunction

    function automatic bit exp_adv(bit st, logic v);
        return !st && v;
    endfunction

    function automatic bit exp_next(bit st, logic v, logic [15:0] w, bit pm, logic rs);
        if (st) return !rs;
        return v && (w == BRKW) && pm;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check mid-cycle, update model at posedge.
    task automatic step(logic [15:0] w, logic v, logic [LW-1:0] lk,
                        logic fp, logic fd, logic rs);
        bit    pm;
        bit    nx;
        string atag;
        @(negedge clk);
        instr_word = w; instr_valid = v; lock_bits = lk;
        fuse_port_n = fp; fuse_dbg_n = fd; resume_req = rs;
        #1;
        pm = exp_permit(lk, fp, fd);
        check(m_tag, cpu_stall, m_stall, "cpu_stall");
        if (m_stall)                   atag = "R6";
        else if (v && w == BRKW && pm) atag = "R3";
        else if (v && w == BRKW)       atag = (lk != '0) ? "R4" : "R5";
        else                           atag = "R8";
        check(atag, pc_advance, exp_adv(m_stall, v), "pc_advance");
        nx = exp_next(m_stall, v, w, pm, rs);
        if (m_stall && rs)      m_tag = "R7";
        else if (m_stall)       m_tag = (lk != '0 || fp || fd) ? "R9" : "R6";
        else if (nx)            m_tag = "R2";
        else if (v && w == BRKW) m_tag = (lk != '0) ? "R4" : "R5";
        else                    m_tag = (rs ? "R7" : "R8");
        @(posedge clk);
        m_stall = nx;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, also with a break word presented during reset
        instr_word = BRKW; instr_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", cpu_stall, 1'b0, "cpu_stall in reset");
        @(negedge clk);
        rst_n = 1'b1;
        instr_valid = 1'b0;
        #1;
        check("R1", cpu_stall, 1'b0, "cpu_stall after reset");

        // R8: ordinary word, and break word without valid
        step(16'h0000, 1'b1, '0, 0, 0, 0);
        step(BRKW, 1'b0, '0, 0, 0, 0);
        step(16'h1234, 1'b0, '0, 0, 0, 0);
        // R7: resume while running has no effect
        step(16'h0000, 1'b1, '0, 0, 0, 1);
        // R3 then R2: permitted break enters the stopped state
        step(BRKW, 1'b1, '0, 0, 0, 0);
        // R6: words ignored while stopped, including another break
        step(BRKW, 1'b1, '0, 0, 0, 0);
        step(16'hFFFF, 1'b1, '0, 0, 0, 0);
        // R9: permission withdrawn while stopped does not release
        step(16'h0000, 1'b0, 2'b11, 1, 1, 0);
        step(16'h0000, 1'b0, 2'b01, 0, 1, 0);
        // R7: resume arrives together with a valid break word
        step(BRKW, 1'b1, '0, 0, 0, 1);
        step(16'h0000, 1'b1, '0, 0, 0, 0);
        // R4: each lock bit alone turns the break into a no-op
        step(BRKW, 1'b1, 2'b01, 0, 0, 0);
        step(BRKW, 1'b1, 2'b10, 0, 0, 0);
        // R5: either fuse unprogrammed turns the break into a no-op
        step(BRKW, 1'b1, '0, 1, 0, 0);
        step(BRKW, 1'b1, '0, 0, 1, 0);
        step(16'h0000, 1'b0, '0, 0, 0, 0);
        // Near-miss opcodes
        step(BRKW ^ 16'h0001, 1'b1, '0, 0, 0, 0);
        step(BRKW ^ 16'h8000, 1'b1, '0, 0, 0, 0);
        step(16'h0000, 1'b0, '0, 0, 0, 0);

        // Constrained random with a fixed seed
        void'($urandom(32'd7001));
        for (int i = 0; i < 4000; i++) begin
            logic [15:0]   w;
            logic          v;
            logic [LW-1:0] lk;
            logic          fp;
            logic          fd;
            logic          rs;
            w  = ($urandom % 3 == 0) ? BRKW : 16'($urandom);
            v  = ($urandom % 4 != 0);
            lk = ($urandom % 4 == 0) ? LW'($urandom) : '0;
            fp = ($urandom % 6 == 0);
            fd = ($urandom % 6 == 0);
            rs = ($urandom % 5 == 0);
            step(w, v, lk, fp, fd, rs);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule